// File: doc/BRIEF.md
# General Call Software Reset Sequencer

This block sits behind a bit-level I2C target engine and watches the byte-level events that engine decodes: START, repeated START, STOP, and each received byte together with its position in the current transfer. It recognises one sequence only, the general-call software reset. The first byte of the transfer must be the general-call address with the write direction (00h). The second byte must be the reset code 06h. A STOP must then close the transfer.

For every received byte the block gives an acknowledge decision in the same cycle. When the full sequence has been acknowledged and a STOP arrives, it emits a single-cycle reset pulse. The rest of the device uses that pulse to return its registers to their power-up values. Several events cancel the sequence without a reset: a wrong byte, a byte beyond the second, a repeated START, or a fresh START.

Top module: `gcall_reset_seq`

## Requirements
- R1: After reset, `soft_rst_o` is 0 and no byte is acknowledged until a valid first byte arrives.
- R2: A byte of value 00h at index 0, received in the idle state, raises `ack_en_o` in the same cycle that `byte_vld_i` is high.
- R3: A first byte other than 00h, including 01h (general call with read bit), is not acknowledged; later bytes of that transfer are not acknowledged and its STOP gives no reset.
- R4: After an acknowledged 00h, a byte at index 1 equal to 06h is acknowledged; any other value is not, and the sequence is abandoned so that STOP gives no reset.
- R5: Any byte at index 2 or later is never acknowledged.
- R6: A STOP after an acknowledged 06h makes `soft_rst_o` high for exactly one cycle, in the cycle after the STOP strobe.
- R7: A repeated START after an acknowledged 06h gives no reset, and the sequencer is ready at once to acknowledge a new 00h at index 0.
- R8: A third byte after the acknowledged 06h disarms the sequence, so the following STOP gives no reset.
- R9: A START always returns the sequencer to idle: an armed sequence followed by START and then STOP gives no reset.
- R10: After a reset pulse the sequencer is idle, and a new complete sequence gives a second pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | START condition strobe |
| rstart_i | input | 1 | Repeated START strobe |
| stop_i | input | 1 | STOP condition strobe |
| byte_vld_i | input | 1 | Received byte strobe |
| byte_i | input | 8 | Received byte value |
| byte_idx_i | input | IDX_W | Position of the byte in the transfer, 0 for the address byte |
| ack_en_o | output | 1 | Acknowledge decision for the byte on `byte_i` (combinational) |
| soft_rst_o | output | 1 | Single-cycle software reset pulse |

## Verification
The assertions assume that the engine presents at most one event per cycle. START, repeated START, STOP and byte strobes are therefore mutually exclusive. They also assume that every transfer begins with a START. The bench drives each event as a one-cycle strobe from its own task and returns all strobes to zero between events. Each transfer it builds opens with a START, and the byte index counts up from zero within it.

// File: rtl/gcall_reset_seq.sv
module gcall_reset_seq #(
  parameter int          IDX_W    = 3,
  parameter logic [7:0]  GC_ADDR  = 8'h00,
  parameter logic [7:0]  RST_CODE = 8'h06
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             rstart_i,
  input  logic             stop_i,
  input  logic             byte_vld_i,
  input  logic [7:0]       byte_i,
  input  logic [IDX_W-1:0] byte_idx_i,
  output logic             ack_en_o,
  output logic             soft_rst_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_ARMED, ST_DEAD} st_t;

  st_t st, st_nx;

  wire is_first  = (byte_idx_i == '0);
  wire is_second = (byte_idx_i == IDX_W'(1));
  wire hit_addr  = byte_vld_i && (st == ST_IDLE) && is_first  && (byte_i == GC_ADDR);
  wire hit_code  = byte_vld_i && (st == ST_ADDR) && is_second && (byte_i == RST_CODE);
  wire any_cond  = start_i | rstart_i | stop_i;

  assign ack_en_o = hit_addr | hit_code;

  always_comb begin
    st_nx = st;
    if (any_cond)
      st_nx = ST_IDLE;
    else if (byte_vld_i)
      st_nx = hit_addr ? ST_ADDR : (hit_code ? ST_ARMED : ST_DEAD);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      soft_rst_o <= 1'b0;
    end else begin
      st         <= st_nx;
      soft_rst_o <= stop_i && (st == ST_ARMED);
    end
  end

  // input assumption: one event per cycle
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_i, rstart_i, stop_i, byte_vld_i}));

  // R2
  ack_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_en_o |-> byte_vld_i);

  // R5
  late_byte_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld_i && byte_idx_i > IDX_W'(1)) |-> !ack_en_o);

  // R6
  rst_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(soft_rst_o) |-> $past(stop_i));

  // R6
  rst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |=> !soft_rst_o);

  // R7
  rstart_no_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rstart_i |=> !soft_rst_o);

  // R9
  start_no_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !soft_rst_o);
endmodule

// File: tb/sim_gcall_reset_seq.sv
module sim_gcall_reset_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0, rstart_i = 1'b0, stop_i = 1'b0, byte_vld_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic [2:0] byte_idx_i = 3'd0;
  logic       ack_en_o, soft_rst_o;
  int         total = 0, bad = 0;

  always #4 clk = ~clk;

  gcall_reset_seq #(.IDX_W(3)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rstart_i(rstart_i),
    .stop_i(stop_i), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
    .byte_idx_i(byte_idx_i), .ack_en_o(ack_en_o), .soft_rst_o(soft_rst_o));

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic ev_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic ev_rstart(input string tag);
    @(negedge clk); rstart_i = 1'b1;
    @(negedge clk); rstart_i = 1'b0;
    chk(tag, soft_rst_o, 1'b0);
  endtask

  task automatic ev_stop(input string tag, input logic exp_rst);
    @(negedge clk); stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
    chk(tag, soft_rst_o, exp_rst);
    @(negedge clk);
    chk({tag, " pulse end"}, soft_rst_o, 1'b0);
  endtask

  task automatic ev_byte(input string tag, input logic [7:0] v, input logic [2:0] idx,
                         input logic exp_ack);
    @(negedge clk); byte_vld_i = 1'b1; byte_i = v; byte_idx_i = idx;
    #1 chk(tag, ack_en_o, exp_ack);
    @(negedge clk); byte_vld_i = 1'b0; byte_i = 8'h00; byte_idx_i = 3'd0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 soft_rst after reset", soft_rst_o, 1'b0);
    chk("R1 ack after reset", ack_en_o, 1'b0);
  endtask

  task automatic t_full();
    ev_start();
    ev_byte("R2 ack 00h", 8'h00, 3'd0, 1'b1);
    ev_byte("R4 ack 06h", 8'h06, 3'd1, 1'b1);
    ev_stop("R6 reset on stop", 1'b1);
  endtask

  task automatic t_read_addr();
    ev_start();
    ev_byte("R3 nack 01h", 8'h01, 3'd0, 1'b0);
    ev_byte("R3 nack 06h after bad addr", 8'h06, 3'd1, 1'b0);
    ev_stop("R3 no reset", 1'b0);
    ev_start();
    ev_byte("R3 nack 48h", 8'h48, 3'd0, 1'b0);
    ev_stop("R3 no reset other addr", 1'b0);
  endtask

  task automatic t_bad_code();
    ev_start();
    ev_byte("R2 ack 00h", 8'h00, 3'd0, 1'b1);
    ev_byte("R4 nack 07h", 8'h07, 3'd1, 1'b0);
    ev_stop("R4 no reset bad code", 1'b0);
  endtask

  task automatic t_trailing();
    ev_start();
    ev_byte("R2 ack 00h", 8'h00, 3'd0, 1'b1);
    ev_byte("R4 ack 06h", 8'h06, 3'd1, 1'b1);
    ev_byte("R5 nack third byte", 8'h06, 3'd2, 1'b0);
    ev_byte("R5 nack fourth byte", 8'h00, 3'd3, 1'b0);
    ev_stop("R8 no reset after trailing", 1'b0);
  endtask

  task automatic t_rstart();
    ev_start();
    ev_byte("R2 ack 00h", 8'h00, 3'd0, 1'b1);
    ev_byte("R4 ack 06h", 8'h06, 3'd1, 1'b1);
    ev_rstart("R7 no reset on rstart");
    ev_byte("R7 ack 00h after rstart", 8'h00, 3'd0, 1'b1);
    ev_byte("R7 ack 06h after rstart", 8'h06, 3'd1, 1'b1);
    ev_stop("R7 reset after new sequence", 1'b1);
  endtask

  task automatic t_start_abort();
    ev_start();
    ev_byte("R2 ack 00h", 8'h00, 3'd0, 1'b1);
    ev_byte("R4 ack 06h", 8'h06, 3'd1, 1'b1);
    ev_start();
    chk("R9 no reset on start", soft_rst_o, 1'b0);
    ev_stop("R9 no reset after start", 1'b0);
  endtask

  task automatic t_again();
    t_full();
    ev_start();
    ev_byte("R10 ack 00h again", 8'h00, 3'd0, 1'b1);
    ev_byte("R10 ack 06h again", 8'h06, 3'd1, 1'b1);
    ev_stop("R10 second reset", 1'b1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_full();
        t_read_addr();
        t_bad_code();
        t_trailing();
        t_rstart();
        t_start_abort();
        t_again();
      end
      begin
        repeat (20000) @(negedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule